// File: doc/BRIEF.md
# Coincidence Trigger with Per-System Busy Veto

This block turns pulses from a main timing detector into accepted event triggers. In singles mode every rising edge of the main pulse is a candidate. In coincidence mode a candidate needs a rising edge on the secondary detector input. That edge must arrive in the same cycle as the main edge or within a programmable number of cycles after it. A candidate becomes a one-cycle live trigger only when no readout system is still busy.

Each readout system has its own busy latch. An accepted trigger sets the latch, and only that system's end-of-event edge clears it. The global busy is the OR of the latches, so the veto lasts as long as the slowest enabled readout. A system can be excluded through an enable mask, and its latch is then held clear. When a main pulse does not lead to a live trigger, the block issues a one-cycle fast-clear pulse to the charge digitizer. This happens when the coincidence window runs out or when the candidate is vetoed by busy. All inputs are synchronous to one clock, and every pulse input is edge detected.

Top module: `coinc_trigger_veto`

## Requirements
- R1: In singles mode (coinc_mode = 0), a rising edge of main_in sampled at clock edge t while busy_any is low gives live_trig high for exactly the cycle after edge t.
- R2: In coincidence mode (coinc_mode = 1), a main_in rising edge at clock edge t0 opens a window covering edges t0 through t0 + win_len. The first sec_in rising edge inside the window is a candidate and closes the window. A sec_in edge outside any open window is ignored.
- R3: An accepted trigger sets busy_sys[i] for every enabled system i, visible in the same cycle as live_trig. Each latch stays set until a rising edge of eoe_in[i] and is not touched by the end-of-event edges of other systems.
- R4: busy_any equals the OR of busy_sys, and live_trig never rises for a candidate sampled while busy_any was high.
- R5: fast_clr pulses for one cycle after a candidate vetoed by busy. In coincidence mode it also pulses after the edge t0 + win_len when no sec_in edge came in the window. With win_len = 0 that is the cycle after the main edge itself.
- R6: When sys_en[i] is 0, busy_sys[i] is 0 from the next cycle on and cannot block triggers.
- R7: All pulse inputs act on rising edges only, so a level held high for many cycles produces one event.
- R8: live_trig and fast_clr are each at most one cycle wide per event and are never high in the same cycle.
- R9: While rst_n is low, live_trig, fast_clr, busy_sys and busy_any are all 0 and any open window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| coinc_mode | input | 1 | 0 selects singles, 1 selects coincidence |
| win_len | input | WIN_W | Coincidence window length in cycles after the main edge |
| sys_en | input | N_SYS | Per-system enable for the busy veto |
| main_in | input | 1 | Main timing detector pulse |
| sec_in | input | 1 | Secondary detector pulse |
| eoe_in | input | N_SYS | Per-system end-of-event pulses |
| live_trig | output | 1 | One-cycle accepted trigger |
| fast_clr | output | 1 | One-cycle fast clear for the charge digitizer |
| busy_sys | output | N_SYS | Per-system busy latches |
| busy_any | output | 1 | OR of all busy latches |

## Verification
The assertions assume that coinc_mode and win_len do not change while a coincidence window is open. The window counter is loaded with the length that applies at the main edge. The bench therefore changes the configuration only after an idle stretch longer than the largest window it uses. The checks on latch clearing assume that an end-of-event edge is the only cause of a falling latch apart from a dropped enable. The pseudo-random stimulus drives sys_en and eoe_in only through those two paths, and it changes sys_en only at configuration boundaries.

// File: rtl/trig_veto_pkg.sv
package trig_veto_pkg;

  typedef enum logic {
    MODE_SINGLES = 1'b0,
    MODE_COINC   = 1'b1
  } trig_mode_e;

  // A pulse input produces an event only in the cycle where it goes high.
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // A main pulse is lost when no secondary edge comes by the final window slot.
  function automatic logic window_missed(input logic main_rise, input logic sec_rise,
                                         input logic zero_len, input logic last_slot);
    return ~sec_rise & ((main_rise & zero_len) | (~main_rise & last_slot));
  endfunction

endpackage

// File: rtl/pulse_edge.sv
module pulse_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  import trig_veto_pkg::*;

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise[g] = rise_of(lvl[g], lvl_q[g]);
  end
endmodule

// File: rtl/coinc_window.sv
module coinc_window #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coinc_mode,
  input  logic [WIN_W-1:0] win_len,
  input  logic             main_rise,
  input  logic             sec_rise,
  output logic             raw_evt,
  output logic             miss_evt,
  output logic             win_open
);
  import trig_veto_pkg::*;

  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             coinc;

  assign coinc    = (trig_mode_e'(coinc_mode) == MODE_COINC);
  assign win_open = (cnt_q != '0);

  always_comb begin
    raw_evt  = 1'b0;
    miss_evt = 1'b0;
    cnt_d    = '0;
    if (!coinc) begin
      raw_evt = main_rise;
    end else begin
      raw_evt  = sec_rise & (main_rise | win_open);
      miss_evt = window_missed(main_rise, sec_rise, win_len == '0, cnt_q == ONE);
      if (raw_evt)        cnt_d = '0;
      else if (main_rise) cnt_d = win_len;
      else if (win_open)  cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/busy_bank.sv
module busy_bank #(
  parameter int N_SYS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SYS-1:0] sys_en,
  input  logic             set_evt,
  input  logic [N_SYS-1:0] eoe_rise,
  output logic [N_SYS-1:0] busy_sys,
  output logic             busy_any
);
  for (genvar g = 0; g < N_SYS; g++) begin : g_sys
    logic lat_q;
    always_ff @(posedge clk) begin
      if (!rst_n || !sys_en[g]) lat_q <= 1'b0;
      else if (set_evt)         lat_q <= 1'b1;
      else if (eoe_rise[g])     lat_q <= 1'b0;
    end
    assign busy_sys[g] = lat_q;
  end

  assign busy_any = |busy_sys;
endmodule

// File: rtl/coinc_trigger_veto.sv
module coinc_trigger_veto #(
  parameter int N_SYS = 3,
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coinc_mode,
  input  logic [WIN_W-1:0] win_len,
  input  logic [N_SYS-1:0] sys_en,
  input  logic             main_in,
  input  logic             sec_in,
  input  logic [N_SYS-1:0] eoe_in,
  output logic             live_trig,
  output logic             fast_clr,
  output logic [N_SYS-1:0] busy_sys,
  output logic             busy_any
);
  logic             main_rise, sec_rise;
  logic [N_SYS-1:0] eoe_rise;
  logic             raw_evt, miss_evt, win_open;
  logic             accept_evt, veto_evt;
  logic             live_q, fclr_q;

  pulse_edge #(.W(1)) u_main_edge (
    .clk(clk), .rst_n(rst_n), .lvl(main_in), .rise(main_rise));
  pulse_edge #(.W(1)) u_sec_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sec_in), .rise(sec_rise));
  pulse_edge #(.W(N_SYS)) u_eoe_edge (
    .clk(clk), .rst_n(rst_n), .lvl(eoe_in), .rise(eoe_rise));

  coinc_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .coinc_mode(coinc_mode), .win_len(win_len),
    .main_rise(main_rise), .sec_rise(sec_rise),
    .raw_evt(raw_evt), .miss_evt(miss_evt), .win_open(win_open));

  assign accept_evt = raw_evt & ~busy_any;
  assign veto_evt   = raw_evt & busy_any;

  busy_bank #(.N_SYS(N_SYS)) u_busy (
    .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .set_evt(accept_evt),
    .eoe_rise(eoe_rise), .busy_sys(busy_sys), .busy_any(busy_any));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      fclr_q <= 1'b0;
    end else begin
      live_q <= accept_evt;
      fclr_q <= miss_evt | veto_evt;
    end
  end

  assign live_trig = live_q;
  assign fast_clr  = fclr_q;
endmodule

// File: rtl/trig_veto_chk.sv
module trig_veto_chk #(
  parameter int N_SYS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coinc_mode,
  input logic [N_SYS-1:0] sys_en,
  input logic [N_SYS-1:0] eoe_in,
  input logic             main_rise,
  input logic             raw_evt,
  input logic             win_open,
  input logic             live_trig,
  input logic             fast_clr,
  input logic [N_SYS-1:0] busy_sys,
  input logic             busy_any
);
  // R8
  live_fclr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_trig && fast_clr));

  // R8
  live_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_trig |=> !live_trig);

  // R4
  live_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_trig |-> !$past(busy_any));

  // R1
  singles_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!coinc_mode && main_rise && !busy_any) |=> live_trig);

  // R2
  singles_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coinc_mode |=> !win_open);

  // R3
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_trig |-> (busy_sys == $past(sys_en)));

  // R4
  raw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_evt && busy_any) |=> (!live_trig && fast_clr));

  // R6
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_sys & ~$past(sys_en)) == '0);

  for (genvar g = 0; g < N_SYS; g++) begin : g_lat
    // R3
    latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_sys[g]) |-> ($past(eoe_in[g]) || !$past(sys_en[g])));
  end
endmodule

bind coinc_trigger_veto trig_veto_chk #(.N_SYS(N_SYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .coinc_mode(coinc_mode), .sys_en(sys_en),
  .eoe_in(eoe_in), .main_rise(main_rise), .raw_evt(raw_evt),
  .win_open(win_open), .live_trig(live_trig), .fast_clr(fast_clr),
  .busy_sys(busy_sys), .busy_any(busy_any));

// File: tb/coinc_trigger_veto_tb.sv
module coinc_trigger_veto_tb;
  localparam int CLK_P = 10;
  localparam int N_SYS = 3;
  localparam int WIN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             coinc_mode = 1'b0;
  logic [WIN_W-1:0] win_len = '0;
  logic [N_SYS-1:0] sys_en = '0;
  logic             main_in = 1'b0;
  logic             sec_in = 1'b0;
  logic [N_SYS-1:0] eoe_in = '0;
  logic             live_trig, fast_clr, busy_any;
  logic [N_SYS-1:0] busy_sys;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state, kept as elapsed-cycle bookkeeping
  bit             pm, ps;
  bit [N_SYS-1:0] pe, mb;
  bit             win_on;
  int             cyc, t_main;
  bit             x_live, x_fc;
  logic [31:0]    rng = 32'h1d2c_3b4a;

  always #(CLK_P/2) clk = ~clk;

  coinc_trigger_veto #(.N_SYS(N_SYS), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .coinc_mode(coinc_mode), .win_len(win_len),
    .sys_en(sys_en), .main_in(main_in), .sec_in(sec_in), .eoe_in(eoe_in),
    .live_trig(live_trig), .fast_clr(fast_clr), .busy_sys(busy_sys),
    .busy_any(busy_any));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // advance reference by one edge using the inputs now applied
  task automatic model_edge();
    bit mr, sr, raw, miss, busy;
    bit [N_SYS-1:0] er;
    int w;
    w    = int'(win_len);
    mr   = main_in && !pm;
    sr   = sec_in && !ps;
    er   = eoe_in & ~pe;
    busy = (mb != 0);
    raw  = 0;
    miss = 0;
    if (!coinc_mode) begin
      raw    = mr;
      win_on = 0;
    end else begin
      if (mr) begin win_on = 1; t_main = cyc; end
      if (win_on && (cyc - t_main) <= w) begin
        raw  = sr;
        miss = !sr && ((cyc - t_main) == w);
      end
      if (raw || miss || (win_on && (cyc - t_main) >= w)) win_on = 0;
    end
    x_live = raw && !busy;
    x_fc   = miss || (raw && busy);
    for (int i = 0; i < N_SYS; i++)
      mb[i] = sys_en[i] && (x_live || (mb[i] && !er[i]));
    pm = main_in; ps = sec_in; pe = eoe_in;
    cyc++;
  endtask

  task automatic step(input bit m, input bit s, input bit [N_SYS-1:0] e);
    @(negedge clk);
    main_in = m; sec_in = s; eoe_in = e;
    @(posedge clk);
    model_edge();
    #1;
    check("R1/R2 live_trig", 32'(live_trig), 32'(x_live));
    check("R5 fast_clr", 32'(fast_clr), 32'(x_fc));
    check("R3 busy_sys", 32'(busy_sys), 32'(mb));
    check("R4 busy_any", 32'(busy_any), 32'(mb != 0));
    check("R8 exclusive", 32'(live_trig & fast_clr), 32'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    int wl[4] = '{0, 1, 2, 5};
    int lives;
    repeat (4) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 live_trig", 32'(live_trig), 32'd0);
    check("R9 fast_clr", 32'(fast_clr), 32'd0);
    check("R9 busy_sys", 32'(busy_sys), 32'd0);
    check("R9 busy_any", 32'(busy_any), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    pm = 0; ps = 0; pe = '0; mb = '0; win_on = 0; cyc = 0; t_main = 0;

    // R7 directed: main held high, singles, no systems enabled -> one trigger
    lives = 0;
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, '0);
      lives += int'(live_trig);
    end
    step(1'b0, 1'b0, '0);
    check("R7 held level events", 32'(lives), 32'd1);

    // R6/R3 directed: only system 1 enabled, others' end-of-event cannot clear it
    @(negedge clk); sys_en = 3'b010;
    step(1'b1, 1'b0, '0);
    check("R3 latch set", 32'(busy_sys), 32'h2);
    step(1'b0, 1'b0, 3'b101);
    check("R3 other eoe ignored", 32'(busy_sys), 32'h2);
    step(1'b1, 1'b0, 3'b000);
    check("R4 vetoed live", 32'(live_trig), 32'd0);
    check("R5 vetoed fast clear", 32'(fast_clr), 32'd1);
    step(1'b0, 1'b0, 3'b010);
    check("R3 own eoe clears", 32'(busy_sys), 32'h0);

    // near-exhaustive sweep: mode x window x enable mask
    for (int md = 0; md < 2; md++)
      for (int wi = 0; wi < 4; wi++)
        for (int en = 0; en < (1 << N_SYS); en++) begin
          for (int k = 0; k < 8; k++) step(1'b0, 1'b0, '1);
          for (int k = 0; k < 2; k++) step(1'b0, 1'b0, '0);
          @(negedge clk);
          coinc_mode = md[0];
          win_len    = WIN_W'(wl[wi]);
          sys_en     = N_SYS'(en);
          for (int k = 0; k < 160; k++) begin
            bit [N_SYS-1:0] ev;
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            for (int i = 0; i < N_SYS; i++) ev[i] = (rng[8+3*i +: 3] == 3'd0);
            step(rng[1:0] == 2'd0, rng[3:2] == 2'd0, ev);
          end
        end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule